// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial bus (SCL clock, SDA data), placed in front of a small on-chip byte memory. A faster system clock oversamples both bus lines through synchronizers. Edge detection on the synchronized lines finds clock edges and the two framing conditions: START, where SDA falls while SCL is high, and STOP, where SDA rises while SCL is high. The block never drives SDA high. Its only output is a pull-down enable, which the pad wires into an open-drain driver. The bus line is the wired-AND of the master and this enable.

A transfer begins with a START and an address byte. That byte carries a fixed device code, three chip-select bits and a direction bit. Three strap pins set which of eight devices on the bus this block is. A write transfer carries one word-address byte and one data byte. A STOP then starts a programming timer, and the byte reaches memory when the timer expires. While that timer runs, the block acknowledges nothing. A read returns bytes from an internal pointer, MSB first. It keeps sending bytes for as long as the master acknowledges them. A write that stops after the word address (a "dummy write") only moves the pointer, which sets up a random read.

Top module: `twi_mem_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) aborts any transfer in progress and begins reception of an address byte. A STOP (SDA rising while SCL is high) ends the transfer, returns the block to idle and releases SDA.
- R2: The block drives only a pull-down enable. The enable is 0 out of reset, in idle, and whenever the block is not acknowledging or sending a 0 bit.
- R3: The address byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal `chip_sel[2:0]`. Bit 0 selects the direction (1 = read, 0 = write). A byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R4: For every accepted received byte, the pull-down is asserted in the SCL low period after the 8th pulse. It is held through the whole high period of the 9th pulse and released after the 9th pulse falls.
- R5: In a write, the byte after the address byte is the word address. Its low 7 bits load the pointer and bit 7 is ignored. The next byte is the data byte. Both are acknowledged, and the pointer then advances by one.
- R6: Any byte after the data byte in the same write transfer is not acknowledged, and it is not stored.
- R7: A STOP that follows an acknowledged data byte starts a programming cycle of `PROG_CYCLES` system clocks. The byte is written to memory when that cycle ends. A repeated START in place of the STOP discards the byte and starts no programming cycle.
- R8: While a programming cycle runs, no byte is acknowledged, and that includes the address byte.
- R9: Read data is sent MSB first. It starts at the pointer and changes only while SCL is low. The pointer advances after each byte sent and wraps from 127 to 0.
- R10: If the master acknowledges a read byte (SDA low on the 9th pulse), the next byte follows. If it does not (SDA high), the block stops sending and keeps SDA released until the next START or STOP.
- R11: The pull-down enable changes only while the synchronized SCL is low. It stays constant over every SCL high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_sel | input | 3 | Strap pins selecting the device number (compared with address bits 3:1) |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA (1 = pull low) |

## Verification
The assertions assume a well-behaved master. Each SCL low period must be longer than the synchronizer latency plus one clock. SDA may change only while SCL is low, except for START and STOP. The master must never frame a START or STOP while the slave holds SDA low. Under those conditions, a change of the pull-down can only land in a low period, and programming can only begin from a STOP. The stimulus keeps to this by moving SDA a quarter bit after each SCL fall, and by holding SCL low for 16 clocks between high periods. It also issues STOP or repeated START only after an acknowledge or a not-acknowledge, when the slave has already let go of SDA.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam logic [3:0] DEV_CODE  = 4'b1010;
  localparam int         BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } twi_state_e;

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/twi_prog_timer.sv
module twi_prog_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (launch && cnt == '0) begin
      cnt <= CW'(CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

endmodule

// File: rtl/twi_mem_store.sv
module twi_mem_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int MEM_DEPTH   = 128,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  output logic       sda_pull_o
);

  localparam int AW = $clog2(MEM_DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, prog_done, launch;

  twi_state_e               state;
  logic [3:0]               bitcnt;
  logic [BYTE_BITS-1:0]     shreg;
  logic [AW-1:0]            ptr;
  logic [AW-1:0]            pend_addr;
  logic [BYTE_BITS-1:0]     pend_data;
  logic                     pend_vld;
  logic                     rw_q;
  logic                     mack_q;
  logic                     sda_pull;
  logic [BYTE_BITS-1:0]     rd_data;
  logic                     byte_end;
  logic                     addr_hit;
  logic                     ack_ok;

  twi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy),
    .done   (prog_done)
  );

  twi_mem_store #(.DEPTH(MEM_DEPTH), .DW(BYTE_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prog_done),
    .wr_addr (pend_addr),
    .wr_data (pend_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  assign launch   = stop_det & pend_vld;
  assign byte_end = scl_fall && (bitcnt == 4'd8);
  assign addr_hit = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_sel);
  assign ack_ok   = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_vld  <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
      pend_vld <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
      pend_vld <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (!ack_ok) begin
              state <= ST_IGNORE;
            end else if (state == ST_ADDR) begin
              if (addr_hit) begin
                sda_pull <= 1'b1;
                rw_q     <= shreg[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_WADR) begin
              sda_pull <= 1'b1;
              ptr      <= shreg[AW-1:0];
              state    <= ST_WADR_ACK;
            end else begin
              sda_pull  <= 1'b1;
              pend_addr <= ptr;
              pend_data <= shreg;
              pend_vld  <= 1'b1;
              ptr       <= ptr + 1'b1;
              state     <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              shreg    <= rd_data;
              sda_pull <= ~rd_data[BYTE_BITS-1];
              state    <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            state    <= ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= ST_IGNORE;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            sda_pull <= 1'b0;
            ptr      <= ptr + 1'b1;
            state    <= ST_TX_ACK;
          end else if (scl_fall) begin
            sda_pull <= ~shreg[BYTE_BITS-2];
            shreg    <= {shreg[BYTE_BITS-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack_q) begin
              shreg    <= rd_data;
              sda_pull <= ~rd_data[BYTE_BITS-1];
              state    <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

  assign sda_pull_o = sda_pull;

endmodule

// File: rtl/twi_mem_checker.sv
module twi_mem_checker
  import twi_mem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       busy,
  input logic       sda_pull,
  input twi_state_e state
);

  // R1: a START always restarts address reception
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR);

  // R1: a STOP always returns to idle
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE);

  // R2: released while idle
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_pull);

  // R3, R10: nothing driven while waiting for the next frame
  assert_ignore_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_pull);

  // R7: programming begins only from a STOP
  assert_prog_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R8: silent while programming
  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R11: pull-down only moves while SCL is low
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

endmodule

bind twi_mem_slave twi_mem_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy      (busy),
  .sda_pull  (sda_pull_o),
  .state     (state)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;

  localparam int PROG = 400;
  localparam int Q    = 8;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  twi_mem_slave #(.MEM_DEPTH(128), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_twi_mem_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .chip_sel   (CS),
    .sda_pull_o (sda_pull)
  );

  // reference model state
  logic [7:0] mdl_mem [128];
  int         mdl_ptr = 0;
  bit         mdl_pend = 0;
  int         pend_a = 0;
  logic [7:0] pend_d = '0;
  longint     cyc = 0;
  longint     busy_end = 0;

  int    nchk = 0, nfail = 0;
  int    clk_chk = 0, clk_fail = 0;
  bit    chk_on = 0;
  logic  exp_pull = 1'b0;
  string cur_req = "R2";
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // R11, R4, R9: per-clock comparison over every SCL high period
  always @(negedge clk) begin
    if (chk_on && scl_m && rst_n) begin
      clk_chk++;
      if (sda_pull !== exp_pull) begin
        clk_fail++;
        $display("FAIL %s cycle %0d sda_pull=%0b expected %0b", cur_req, cyc, sda_pull, exp_pull);
      end
    end
  end

  task automatic report;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk + clk_chk, nfail + clk_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic bit addr_ack(input logic [7:0] b);
    return (b[7:4] == 4'hA) && (b[3:1] == CS) && (cyc >= busy_end);
  endfunction

  task automatic bus_start;
    exp_pull = 1'b0;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
    mdl_pend = 0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    exp_pull = 1'b0;
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1;
    if (mdl_pend) begin
      busy_end = cyc + PROG + 8;
      mdl_mem[pend_a] = pend_d;
      mdl_pend = 0;
    end
    tick(3 * Q);
  endtask

  task automatic clock_bit(input logic m, input logic ep, output logic s);
    sda_m = m; tick(Q);
    exp_pull = ep;
    scl_m = 1'b1; tick(Q);
    s = sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ea, input string tag);
    logic s;
    cur_req = tag;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b0, s);
    clock_bit(1'b1, ea, s);
    check({tag, " ack"}, {31'd0, ~s}, {31'd0, ea});
  endtask

  task automatic recv_byte(input bit mack, input string tag);
    logic s;
    logic [7:0] got;
    logic [7:0] exp;
    exp = mdl_mem[mdl_ptr];
    cur_req = tag;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, ~exp[i], s);
      got[i] = s;
    end
    check({tag, " data"}, {24'd0, got}, {24'd0, exp});
    mdl_ptr = (mdl_ptr + 1) % 128;
    cur_req = "R10";
    clock_bit(~mack, 1'b0, s);
  endtask

  task automatic write_byte(input logic [7:0] wa, input logic [7:0] d);
    bus_start();
    send_byte({4'hA, CS, 1'b0}, addr_ack({4'hA, CS, 1'b0}), "R3");
    send_byte(wa, 1'b1, "R5");
    mdl_ptr = wa[6:0];
    send_byte(d, 1'b1, "R5");
    mdl_pend = 1; pend_a = mdl_ptr; pend_d = d;
    mdl_ptr = (mdl_ptr + 1) % 128;
  endtask

  task automatic set_ptr(input logic [7:0] wa);
    bus_start();
    send_byte({4'hA, CS, 1'b0}, 1'b1, "R3");
    send_byte(wa, 1'b1, "R5");
    mdl_ptr = wa[6:0];
    bus_stop();
  endtask

  task automatic read_seq(input int n);
    bus_start();
    send_byte({4'hA, CS, 1'b1}, 1'b1, "R3");
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, "R9");
    bus_stop();
  endtask

  initial begin
    logic s;
    for (int i = 0; i < 128; i++) mdl_mem[i] = '0;
    tick(5);
    check("R2 reset", {31'd0, sda_pull}, 32'd0);
    rst_n = 1'b1;
    tick(5);
    check("R2 after reset", {31'd0, sda_pull}, 32'd0);
    chk_on = 1;

    // R5 R7: byte write, bit 7 of word address ignored
    write_byte(8'h85, 8'hA5);
    bus_stop();
    // R8: address byte during programming gets no acknowledge
    bus_start();
    send_byte({4'hA, CS, 1'b0}, addr_ack({4'hA, CS, 1'b0}), "R8");
    check("R8 busy expected", {31'd0, addr_ack({4'hA, CS, 1'b0})}, 32'd0);
    bus_stop();
    tick(PROG + 20);

    // R9: current-address read follows the write pointer (6)
    read_seq(1);
    // random read of the written byte
    set_ptr(8'h05);
    read_seq(1);

    // R9 wrap: seed 127 and 0, read 126..0
    write_byte(8'h7F, 8'h3C); bus_stop(); tick(PROG + 20);
    write_byte(8'h00, 8'h81); bus_stop(); tick(PROG + 20);
    set_ptr(8'h7E);
    read_seq(3);
    check("R9 wrap pointer", mdl_ptr, 1);
    read_seq(2);

    // R3: wrong chip select and wrong device code
    bus_start();
    send_byte({4'hA, 3'b010, 1'b0}, 1'b0, "R3");
    send_byte(8'h00, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte({4'hB, CS, 1'b1}, 1'b0, "R3");
    cur_req = "R3";
    for (int i = 0; i < 9; i++) clock_bit(1'b1, 1'b0, s);
    bus_stop();

    // R6: extra byte in a write is refused and not stored
    write_byte(8'h0A, 8'h5A);
    send_byte(8'hC3, 1'b0, "R6");
    bus_stop();
    tick(PROG + 20);
    set_ptr(8'h0A);
    read_seq(2);

    // R7: repeated START discards pending byte, no programming
    write_byte(8'h14, 8'h77);
    bus_start();
    send_byte({4'hA, CS, 1'b1}, 1'b1, "R7");
    recv_byte(1'b0, "R7");
    bus_stop();
    set_ptr(8'h14);
    read_seq(1);

    // R1: START in the middle of an address byte aborts it
    bus_start();
    cur_req = "R1";
    for (int i = 0; i < 4; i++) clock_bit(i[0], 1'b0, s);
    bus_start();
    send_byte({4'hA, CS, 1'b1}, 1'b1, "R1");
    recv_byte(1'b0, "R1");
    // R10: after a NACK, further pulses see SDA released
    cur_req = "R10";
    for (int i = 0; i < 9; i++) clock_bit(1'b1, 1'b0, s);
    bus_stop();
    check("R1 idle after stop", {31'd0, sda_pull}, 32'd0);

    tick(20);
    report();
  end

endmodule